// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words as the clock master of a two-wire synchronous link. It produces the shift clock itself and samples one data line. The shift clock is a programmable division of the system clock. Bits arrive least significant first and build up in a shift register. When a word is complete it moves into a two-entry holding queue. Each queue entry holds 8 data bits plus an optional ninth bit. Software-style control inputs select single-word or continuous reception. The status outputs report data ready, overrun and an interrupt request. A read strobe takes the oldest word out of the queue.

The controller is a three-state machine. IDLE keeps the shift clock low. The start transition IDLE to HIGH is taken when reception is wanted: the port is enabled, no overrun is pending, and either continuous enable is set or single enable is set while its word is not yet taken. HIGH drives the shift clock high for one half period. The falling transition HIGH to LOW samples the data line. LOW holds the clock low for one half period. At the end of LOW the bit transition LOW to HIGH is taken in the middle of a word. At a word boundary the machine takes LOW to HIGH if reception is still wanted, and otherwise the stop transition LOW to IDLE. The abort transition returns from HIGH or LOW to IDLE as soon as the port is disabled or both receive enables are low.

Top module: `sync_rx_master`

## Requirements
- R1: While idle, `sclk_out` is low. During reception each shift-clock period lasts 4 × (`divider` + 1) system clocks, with the high half first.
- R2: `sdata_in` is sampled at the system clock edge where `sclk_out` falls. Bit 0 of the word arrives first. One clock after the last falling edge of a word, the word shows on `rd_data` and `rx_ready` is 1.
- R3: With only `single_en` set, exactly one word is received and `sclk_out` then stays low. A new word needs `single_en` to go low and then high again.
- R4: With `cont_en` set, words follow back to back. After `cont_en` is cleared no further word starts.
- R5: With both enables set, reception is continuous: more than one word is received.
- R6: The queue holds two words and returns them oldest first. `rx_ready` is 1 exactly while the queue is not empty. A read strobe on an empty queue changes nothing.
- R7: If a word completes while the queue is full and no read occurs in that cycle, `overrun` rises and the word is dropped. The queue keeps its contents, and no further shift clock is produced while `overrun` is 1.
- R8: `overrun` stays 1 while `cont_en` stays 1. It clears on the clock after `cont_en` goes from 1 to 0.
- R9: With `nine_en` set, words are 9 bits long and bit 8 is stored with its word. `rd_ninth` shows the ninth bit of the oldest entry and moves on with each read. With `nine_en` clear, `rd_ninth` is 0.
- R10: `irq` equals `rx_ready` AND `int_en`.
- R11: On the clock after `port_en` is seen low, the queue is empty, `overrun` is 0 and `sclk_out` is low.
- R12: A read in the same cycle as a word completes on a full queue frees room. The new word is stored and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low clears all state |
| single_en | input | 1 | Receive one word |
| cont_en | input | 1 | Receive continuously; wins over single_en |
| nine_en | input | 1 | 9-bit word mode |
| int_en | input | 1 | Receive interrupt enable |
| divider | input | DIV_W | Shift clock divider value |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| rd_strobe | input | 1 | Read (pop) the oldest word |
| rd_data | output | 8 | Oldest word, data bits |
| rd_ninth | output | 1 | Oldest word, ninth bit |
| rx_ready | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Overrun flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The critical collision is a read strobe arriving on the exact clock edge where the third word's last bit is sampled into a full queue. In that case the pop and the push compete for the same slot. The bench counts shift-clock rising edges until the third word's final bit. It then waits 2 × (`divider` + 1) − 1 system clocks, so that the strobe is sampled on the falling edge itself. This is repeated for several divider values. The test passes when `overrun` stays low and the two following reads return the second and third words in order.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW
    } rx_state_t;

    typedef struct packed {
        logic              ninth;
        logic [DATA_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
    import sync_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rx_word_t                   push_word,
    input  logic                       pop,
    output rx_word_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rx_word_t         mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = pop && (cnt_q != '0);
    assign push_ok = push && ((cnt_q < CNT_W'(DEPTH)) || pop_ok);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (push_ok && !flush && (wr_q == PTR_W'(g))) begin
                mem_q[g] <= push_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= ptr_inc(wr_q);
            if (pop_ok)  rd_q <= ptr_inc(rd_q);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem_q[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
    import sync_rx_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             single_en,
    input  logic             cont_en,
    input  logic             nine_en,
    input  logic [DIV_W-1:0] divider,
    input  logic             sdata_in,
    input  logic             fifo_room,
    output logic             sclk,
    output logic             push,
    output rx_word_t         push_word,
    output logic             overrun
);
    localparam int unsigned CNT_W = DIV_W + 1;
    localparam int unsigned BIT_W = $clog2(DATA_W + 1);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic [DATA_W:0]  sr_q, sr_d;
    logic             single_done_q, ovr_q, cont_q;
    logic             half_end, any_en, want, sample, last_bit, ovr_set;

    // half period = 2*(divider+1) clocks, so the last count is 2*divider+1
    assign half_end = (cnt_q == {divider, 1'b1});
    assign any_en   = cont_en || single_en;
    assign want     = port_en && !ovr_q && (cont_en || (single_en && !single_done_q));
    assign sample   = (state_q == ST_HIGH) && half_end && port_en && any_en;
    assign last_bit = (bit_q == (nine_en ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1)));
    assign ovr_set  = sample && last_bit && !fifo_room && !ovr_q;

    always_comb begin
        sr_d = (bit_q == '0) ? '0 : sr_q;
        sr_d[bit_q] = sdata_in;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (want) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!port_en || !any_en) state_d = ST_IDLE;
                else if (half_end)       state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!port_en || !any_en) state_d = ST_IDLE;
                else if (half_end) begin
                    if (bit_q != '0) state_d = ST_HIGH;
                    else             state_d = want ? ST_HIGH : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q         <= '0;
            bit_q         <= '0;
            sr_q          <= '0;
            single_done_q <= 1'b0;
            ovr_q         <= 1'b0;
            cont_q        <= 1'b0;
        end else begin
            cont_q <= cont_en;
            cnt_q  <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (!port_en || state_d == ST_IDLE && state_q != ST_LOW) begin
                bit_q <= '0;
            end else if (sample) begin
                bit_q <= last_bit ? '0 : bit_q + 1'b1;
            end
            if (sample) sr_q <= sr_d;
            if (!port_en || !single_en)             single_done_q <= 1'b0;
            else if (sample && last_bit && !cont_en) single_done_q <= 1'b1;
            if (!port_en)                ovr_q <= 1'b0;
            else if (cont_q && !cont_en) ovr_q <= 1'b0;
            else if (ovr_set)            ovr_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sclk            = (state_q == ST_HIGH);
        push            = sample && last_bit && fifo_room && !ovr_q;
        push_word.ninth = nine_en && sr_d[DATA_W];
        push_word.data  = sr_d[DATA_W-1:0];
        overrun         = ovr_q;
    end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
    import sync_rx_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              single_en,
    input  logic              cont_en,
    input  logic              nine_en,
    input  logic              int_en,
    input  logic [DIV_W-1:0]  divider,
    input  logic              sdata_in,
    output logic              sclk_out,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ninth,
    output logic              rx_ready,
    output logic              overrun,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

    logic             push, pop, room;
    rx_word_t         push_word, head;
    logic [CNT_W-1:0] fifo_count;

    assign pop  = rd_strobe && port_en;
    assign room = (fifo_count < CNT_W'(FIFO_DEPTH)) || (pop && (fifo_count != '0));

    sync_rx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .single_en (single_en),
        .cont_en   (cont_en),
        .nine_en   (nine_en),
        .divider   (divider),
        .sdata_in  (sdata_in),
        .fifo_room (room),
        .sclk      (sclk_out),
        .push      (push),
        .push_word (push_word),
        .overrun   (overrun)
    );

    sync_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!port_en),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .count     (fifo_count)
    );

    assign rd_data  = head.data;
    assign rd_ninth = head.ninth && (fifo_count != '0);
    assign rx_ready = (fifo_count != '0);
    assign irq      = rx_ready && int_en;
endmodule

// File: rtl/sync_rx_master_checker.sv
module sync_rx_master_checker #(
    parameter int unsigned DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       port_en,
    input logic                       cont_en,
    input logic                       int_en,
    input logic                       rd_strobe,
    input logic                       sclk_out,
    input logic                       rx_ready,
    input logic                       overrun,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rx_ready && int_en));

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!rx_ready && !overrun && !sclk_out));

    assert_overrun_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && cont_en && port_en) |=> overrun);

    assert_overrun_freezes_fifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_strobe && port_en) |=> $stable(fifo_count));

    assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (fifo_count == ($clog2(DEPTH+1))'(DEPTH)));

    assert_no_clock_in_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !$rose(sclk_out));

    assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind sync_rx_master sync_rx_master_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .cont_en    (cont_en),
    .int_en     (int_en),
    .rd_strobe  (rd_strobe),
    .sclk_out   (sclk_out),
    .rx_ready   (rx_ready),
    .overrun    (overrun),
    .irq        (irq),
    .fifo_count (fifo_count)
);

// File: tb/sync_rx_master_test.sv
module sync_rx_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic port_en = 1'b0, single_en = 1'b0, cont_en = 1'b0, nine_en = 1'b0, int_en = 1'b0;
    logic [DIV_W-1:0] divider = '0;
    logic sdata_in = 1'b0, rd_strobe = 1'b0;
    logic sclk_out, rd_ninth, rx_ready, overrun, irq;
    logic [7:0] rd_data;

    int compared = 0, mismatched = 0;
    int rises = 0, falls = 0, ptr = 0;
    logic [63:0] stream = '0;
    bit done = 1'b0;

    sync_rx_master #(.DIV_W(DIV_W), .FIFO_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_en(single_en),
        .cont_en(cont_en), .nine_en(nine_en), .int_en(int_en), .divider(divider),
        .sdata_in(sdata_in), .sclk_out(sclk_out), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_ninth(rd_ninth), .rx_ready(rx_ready),
        .overrun(overrun), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin @(posedge sclk_out); rises++; end
    initial forever begin @(negedge sclk_out); falls++; end
    initial forever begin
        @(posedge sclk_out);
        @(negedge clk);
        sdata_in = stream[ptr[5:0]];
        ptr++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [63:0] s);
        stream = s; ptr = 0; rises = 0; falls = 0;
    endtask

    task automatic wait_falls(input int n);
        int guard = 0;
        while (falls < n && guard < 20000) begin @(negedge clk); guard++; end
        tick(2);
    endtask

    task automatic pop_word();
        rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0;
    endtask

    task automatic flush_port();
        port_en = 1'b0; tick(2); port_en = 1'b1; tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 idle clock low", sclk_out, 0);
        check("R6 ready low after reset", rx_ready, 0);
        check("R7 overrun low after reset", overrun, 0);
        check("R10 irq low after reset", irq, 0);
        port_en = 1'b1;
        tick(1);
        pop_word(); // read of an empty queue
        tick(1);
        check("R6 empty read ignored", rx_ready, 0);

        for (int d = 0; d < 4; d++) begin
            logic [7:0] wa, wb, wc, wd;
            realtime t0;
            int half;
            if (d == 2) continue;
            divider = DIV_W'(d);
            half = 2 * (d + 1);
            wa = 8'h35 + 8'(d * 17);
            wb = 8'hC9 ^ 8'(d * 5);
            wc = 8'h5A + 8'(d);
            wd = 8'h81 ^ 8'(d * 3);

            // continuous reception up to overrun (R1,R2,R4,R6,R7,R8)
            restart({40'd0, wc, wb, wa});
            cont_en = 1'b1;
            @(posedge sclk_out); t0 = $realtime;
            @(posedge sclk_out);
            check("R1 shift clock period", 32'(int'(($realtime - t0) / CLK_PERIOD)), 32'(4 * (d + 1)));
            wait_falls(24);
            check("R7 overrun set on third word", overrun, 1);
            check("R4 back to back words", falls, 24);
            tick(60);
            check("R7 clock stopped under overrun", rises, 24);
            check("R2 first word data", rd_data, wa);
            check("R6 ready with data", rx_ready, 1);
            pop_word();
            check("R6 second word order", rd_data, wb);
            pop_word();
            check("R6 ready clears when empty", rx_ready, 0);
            check("R8 overrun held while continuous", overrun, 1);
            cont_en = 1'b0; tick(2);
            check("R8 overrun cleared by continuous off", overrun, 0);
            tick(40);
            check("R4 no word after continuous off", rises, 24);

            // read landing on the completion edge (R12)
            restart({40'd0, wd, wb, wa});
            cont_en = 1'b1;
            while (rises < 23) @(negedge clk);
            @(posedge sclk_out);
            repeat (half - 1) @(posedge clk);
            @(negedge clk);
            check("R12 head before collision read", rd_data, wa);
            rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0; cont_en = 1'b0;
            tick(3);
            check("R12 no overrun on collision", overrun, 0);
            check("R12 next word", rd_data, wb);
            pop_word();
            check("R12 collided word stored", rd_data, wd);
            pop_word();
            check("R12 queue empty", rx_ready, 0);

            // both enables: continuous wins (R5)
            restart({40'd0, wc, wb, wa});
            single_en = 1'b1; cont_en = 1'b1;
            while (falls < 16) @(negedge clk);
            single_en = 1'b0; cont_en = 1'b0;
            tick(20);
            check("R5 second word received", rd_data, wa);
            pop_word();
            check("R5 continuous precedence", rd_data, wb);
            check("R5 no overrun", overrun, 0);
            flush_port();
        end

        // single 9-bit words (R3, R9, R10, R11)
        divider = DIV_W'(1);
        nine_en = 1'b1; int_en = 1'b1;
        restart({55'd0, 1'b1, 8'hA7});
        single_en = 1'b1;
        wait_falls(9);
        tick(60);
        check("R3 exactly one word clocked", rises, 9);
        check("R10 irq with enable", irq, 1);
        single_en = 1'b0; tick(2);
        restart({55'd0, 1'b0, 8'h3C});
        single_en = 1'b1;
        wait_falls(9);
        tick(10);
        check("R3 rearmed single word", rises, 9);
        check("R9 ninth bit first entry", rd_ninth, 1);
        check("R9 first entry data", rd_data, 8'hA7);
        pop_word();
        check("R9 ninth bit advances", rd_ninth, 0);
        check("R9 second entry data", rd_data, 8'h3C);
        int_en = 1'b0; tick(1);
        check("R10 irq masked", irq, 0);
        port_en = 1'b0; tick(2);
        check("R11 disable empties queue", rx_ready, 0);
        check("R11 disable clock low", sclk_out, 0);
        port_en = 1'b1; single_en = 1'b0; nine_en = 1'b0;
        tick(5);
        check("R11 still empty after enable", rx_ready, 0);

        done = 1'b1;
        summary();
    end
endmodule